// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs the external memory and I/O bus cycles of an 8-bit processor with a 20-bit address bus and an 8-bit data bus. The core hands it one cycle at a time over a valid/ready port: the kind of cycle, the address, the write data, and flags for opcode fetch and interrupt acknowledge. The block then drives the active-low strobes through T1, T2, any wait states and T3. It returns read data together with a one-clock done pulse.

Besides the raw strobes, the block drives two shared pins. A pin-select control bit chooses what they carry. With the bit clear, the pins carry combined memory-read and memory-write strobes. With the bit set, one pin carries the raw memory request and the other carries an alternate signal. The block also handles bus handover to an external master. It floats its outputs while halted, and it can hold off the first cycle for 16 clocks after a halt ends.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst` is high and on the first clock after it: all strobes, `pin_a_o` and `pin_b_o` are 1, `done` is 0, `busack_n` and `halt_n` are 1, and `addr_oe`/`data_oe` are 0. Once idle after reset, `addr_oe` is 1.
- R2: A request is taken on a clock where `req_valid` and `req_ready` are both 1. With no wait states the request strobe stays low for exactly 3 clocks (T1, T2, T3). `rd_n` is low for all 3 clocks on reads, and `wr_n` is low for the last 2 on writes. `rd_n`, `wr_n` and `m1_n` are high on the clock the request strobe rises, and `done` is 1 for the clock that follows.
- R3: `wait_n` is sampled on the clock ending T2 and on the clock ending each wait state. Every low sample adds one clock to the cycle.
- R4: On reads, `rdata` holds the `data_i` value sampled at the end of T3 while `done` is 1. On writes, `data_oe` is 1 and `data_o` carries the write data for the whole cycle.
- R5: `req_kind` encodes the cycle: bit 1 = I/O, bit 0 = write (00 memory read, 01 memory write, 10 I/O read, 11 I/O write). I/O cycles assert `iorq_n` rather than `mreq_n` and drive `addr_o[19:16]` as 0 with the low 16 request bits.
- R6: A memory read with `req_fetch` set drives `m1_n` low for the whole cycle when `m1_en` was 1 at acceptance. When `m1_en` was 0, `m1_n` stays high.
- R7: An I/O read with `req_intack` set drives `iorq_n` and `m1_n` low together and keeps `rd_n` and `mreq_n` high. The vector on `data_i` is returned in `rdata`.
- R8: With `pin_sel` = 0, `pin_a_o` is low only while both `mreq_n` and `rd_n` are low, and `pin_b_o` is low only while both `mreq_n` and `wr_n` are low. Both pins are always driven.
- R9: With `pin_sel` = 1, `pin_a_o` carries `mreq_n` and `pin_b_o` carries `alt_b_i`. `pin_sel` is only taken between cycles, so a change during a cycle leaves that cycle's pins unchanged.
- R10: When `busreq_n` is low, any cycle in progress finishes first. The next clock floats `addr_oe`, `data_oe` and `ctrl_oe`, and one clock later `busack_n` goes low. During the grant `pin_a` is driven high when `pin_sel` = 0 and floated when `pin_sel` = 1.
- R11: `busack_n` returns high on the clock after `busreq_n` is sampled high, and `addr_oe` returns to 1 on that same clock.
- R12: While idle, `halt_req` = 1 drives `halt_n` low and floats the address and data buses. No request is accepted while halted.
- R13: After `halt_req` falls, `halt_n` rises on the next clock. With `halt_dly_en` = 0 a waiting request's T1 starts 1 clock after `halt_n` rises. With `halt_dly_en` = 1 it starts 17 clocks after, so 16 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Request taken this clock |
| req_kind | input | 2 | Bit 1 I/O, bit 0 write |
| req_fetch | input | 1 | Memory read is an opcode fetch |
| req_intack | input | 1 | I/O read is an interrupt acknowledge |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock pulse after T3 |
| rdata | output | 8 | Read data of the last read |
| wait_n | input | 1 | Wait request, active low |
| busreq_n | input | 1 | External bus request, active low |
| busack_n | output | 1 | Bus grant, active low |
| halt_req | input | 1 | Core is in halt or sleep |
| halt_n | output | 1 | Halt status, active low |
| m1_en | input | 1 | Allow machine-cycle-one on fetches |
| halt_dly_en | input | 1 | Enable the 16-clock restart delay |
| pin_sel | input | 1 | Shared pin function select |
| alt_b_i | input | 1 | Alternate signal for shared pin B |
| addr_o | output | 20 | Address bus |
| addr_oe | output | 1 | Address bus drive enable |
| data_o | output | 8 | Data bus out |
| data_oe | output | 1 | Data bus drive enable |
| data_i | input | 8 | Data bus in |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| m1_n | output | 1 | Machine cycle one |
| ctrl_oe | output | 1 | Strobe drive enable |
| pin_a_o | output | 1 | Shared pin A value |
| pin_a_oe | output | 1 | Shared pin A drive enable |
| pin_b_o | output | 1 | Shared pin B value |
| pin_b_oe | output | 1 | Shared pin B drive enable |

## Verification
On every clock, the assertions check the following:
- read and write strobes never overlap;
- all strobes release together;
- a low wait sample always adds a wait state;
- I/O addresses keep their top nibble at zero;
- the buses stay floated under a grant or a halt;
- the pin-select latch holds still inside a cycle;
- the grant drops one clock after the request is released.

Only the bench scenarios can show the following:
- exact cycle lengths for a given number of wait clocks;
- returned read data and interrupt vectors;
- the shared-pin waveforms in each select mode, and the effect of a mid-cycle select change;
- the grant waiting for a cycle in progress;
- the 1-versus-17-clock restart gap after halt.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_FLT, ST_GNT, ST_HLT, ST_DLY
  } bcc_state_e;

  function automatic logic in_cycle(input bcc_state_e s);
    return (s == ST_T1) || (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction

  function automatic logic late_cycle(input bcc_state_e s);
    return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction
endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
#(
  parameter int RESTART_DLY = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       wait_n,
  input  logic       busreq_n,
  input  logic       halt_req,
  input  logic       halt_dly_en,
  output bcc_state_e state_q,
  output bcc_state_e state_d,
  output logic       busack_n,
  output logic       halt_n,
  output logic       done
);
  localparam int CNT_W = $clog2(RESTART_DLY + 1);

  logic [CNT_W-1:0] cnt_q;

  assign req_ready = (state_q == ST_IDLE) && busreq_n && !halt_req;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (!busreq_n)      state_d = ST_FLT;
        else if (halt_req)  state_d = ST_HLT;
        else if (req_valid) state_d = ST_T1;
      end
      ST_T1:        state_d = ST_T2;
      ST_T2, ST_TW: state_d = wait_n ? ST_T3 : ST_TW;
      ST_T3:        state_d = ST_IDLE;
      ST_FLT:       state_d = busreq_n ? ST_IDLE : ST_GNT;
      ST_GNT:       state_d = busreq_n ? ST_IDLE : ST_GNT;
      ST_HLT: begin
        if (!halt_req) state_d = halt_dly_en ? ST_DLY : ST_IDLE;
      end
      ST_DLY: begin
        if (cnt_q == CNT_W'(RESTART_DLY - 1)) state_d = ST_IDLE;
      end
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      busack_n <= 1'b1;
      halt_n   <= 1'b1;
      done     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= (state_q == ST_DLY) ? cnt_q + 1'b1 : '0;
      busack_n <= (state_d != ST_GNT);
      halt_n   <= (state_d != ST_HLT);
      done     <= (state_q == ST_T3);
    end
  end
endmodule

// File: rtl/bcc_strobe.sv
module bcc_strobe
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bcc_state_e        state_q,
  input  bcc_state_e        state_d,
  input  logic              accept,
  input  logic [1:0]        req_kind,
  input  logic              req_fetch,
  input  logic              req_intack,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              m1_en,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              m1_n,
  output logic              ctrl_oe,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = ADDR_W - IO_W;

  logic [1:0] kind_q, kind_n;
  logic       fetch_q, fetch_n, intack_q, intack_n;
  logic       cyc_d, late_d, is_io, is_wr, floated;

  assign kind_n   = accept ? req_kind : kind_q;
  assign fetch_n  = accept ? (req_fetch && m1_en && (req_kind == 2'b00)) : fetch_q;
  assign intack_n = accept ? (req_intack && (req_kind == 2'b10)) : intack_q;
  assign is_io    = kind_n[1];
  assign is_wr    = kind_n[0];
  assign cyc_d    = in_cycle(state_d);
  assign late_d   = late_cycle(state_d);
  assign floated  = (state_d == ST_FLT) || (state_d == ST_GNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= 2'b00;
      fetch_q  <= 1'b0;
      intack_q <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
      rdata    <= '0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      mreq_n   <= 1'b1;
      iorq_n   <= 1'b1;
      m1_n     <= 1'b1;
      ctrl_oe  <= 1'b0;
      addr_oe  <= 1'b0;
      data_oe  <= 1'b0;
    end else begin
      kind_q   <= kind_n;
      fetch_q  <= fetch_n;
      intack_q <= intack_n;
      if (accept) begin
        addr_o <= req_kind[1] ? {{HI_W{1'b0}}, req_addr[IO_W-1:0]} : req_addr;
        data_o <= req_wdata;
      end
      if ((state_q == ST_T3) && !kind_q[0]) rdata <= data_i;
      mreq_n  <= !(cyc_d && !is_io);
      iorq_n  <= !(cyc_d && is_io);
      rd_n    <= !(cyc_d && !is_wr && !intack_n);
      wr_n    <= !(late_d && is_wr);
      m1_n    <= !(cyc_d && (fetch_n || intack_n));
      data_oe <= cyc_d && is_wr;
      ctrl_oe <= !floated;
      addr_oe <= !(floated || (state_d == ST_HLT));
    end
  end
endmodule

// File: rtl/bcc_pinmux.sv
module bcc_pinmux
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bcc_state_e state_q,
  input  logic       pin_sel,
  input  logic       mreq_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       ctrl_oe,
  input  logic       alt_b_i,
  output logic       sel_q,
  output logic       pin_a_o,
  output logic       pin_a_oe,
  output logic       pin_b_o,
  output logic       pin_b_oe
);
  always_ff @(posedge clk) begin
    if (rst)                      sel_q <= 1'b0;
    else if (!in_cycle(state_q))  sel_q <= pin_sel;
  end

  assign pin_a_o  = sel_q ? mreq_n : (mreq_n | rd_n);
  assign pin_a_oe = sel_q ? ctrl_oe : 1'b1;
  assign pin_b_o  = sel_q ? alt_b_i : (mreq_n | wr_n);
  assign pin_b_oe = 1'b1;
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int IO_W        = 16,
  parameter int DATA_W      = 8,
  parameter int RESTART_DLY = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_fetch,
  input  logic              req_intack,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              wait_n,
  input  logic              busreq_n,
  output logic              busack_n,
  input  logic              halt_req,
  output logic              halt_n,
  input  logic              m1_en,
  input  logic              halt_dly_en,
  input  logic              pin_sel,
  input  logic              alt_b_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              m1_n,
  output logic              ctrl_oe,
  output logic              pin_a_o,
  output logic              pin_a_oe,
  output logic              pin_b_o,
  output logic              pin_b_oe
);
  bcc_state_e state_q, state_d;
  logic       sel_q;

  bcc_seq #(.RESTART_DLY(RESTART_DLY)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .wait_n(wait_n), .busreq_n(busreq_n), .halt_req(halt_req),
    .halt_dly_en(halt_dly_en), .state_q(state_q), .state_d(state_d),
    .busack_n(busack_n), .halt_n(halt_n), .done(done)
  );

  bcc_strobe #(.ADDR_W(ADDR_W), .IO_W(IO_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d),
    .accept(req_valid && req_ready), .req_kind(req_kind),
    .req_fetch(req_fetch), .req_intack(req_intack), .req_addr(req_addr),
    .req_wdata(req_wdata), .m1_en(m1_en), .data_i(data_i),
    .rd_n(rd_n), .wr_n(wr_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .m1_n(m1_n), .ctrl_oe(ctrl_oe), .addr_o(addr_o), .addr_oe(addr_oe),
    .data_o(data_o), .data_oe(data_oe), .rdata(rdata)
  );

  bcc_pinmux u_pinmux (
    .clk(clk), .rst(rst), .state_q(state_q), .pin_sel(pin_sel),
    .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .ctrl_oe(ctrl_oe),
    .alt_b_i(alt_b_i), .sel_q(sel_q), .pin_a_o(pin_a_o),
    .pin_a_oe(pin_a_oe), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe)
  );
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input bcc_state_e        state_q,
  input logic              sel_q,
  input logic              wait_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              m1_n,
  input logic              busreq_n,
  input logic              busack_n,
  input logic              halt_n,
  input logic              addr_oe,
  input logic              data_oe,
  input logic [ADDR_W-1:0] addr_o
);
  p_rdwr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_release_together_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(mreq_n) || $rose(iorq_n)) |-> (rd_n && wr_n && m1_n));

  p_wait_extends_r3: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_T2 || state_q == ST_TW) && !wait_n) |=> (state_q == ST_TW));

  p_io_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !iorq_n |-> (addr_o[ADDR_W-1:IO_W] == '0));

  p_m1_with_req_r6: assert property (@(posedge clk) disable iff (rst)
    !m1_n |-> (!mreq_n || !iorq_n));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (rst)
    late_cycle(state_q) |-> $stable(sel_q));

  p_grant_float_r10: assert property (@(posedge clk) disable iff (rst)
    !busack_n |-> (!addr_oe && !data_oe && mreq_n && iorq_n));

  p_grant_release_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(busreq_n) && !busack_n) |=> busack_n);

  p_halt_float_r12: assert property (@(posedge clk) disable iff (rst)
    !halt_n |-> (!addr_oe && !data_oe));
endmodule

bind bus_cycle_ctrl bcc_checker #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .sel_q(sel_q), .wait_n(wait_n),
  .rd_n(rd_n), .wr_n(wr_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
  .busreq_n(busreq_n), .busack_n(busack_n), .halt_n(halt_n),
  .addr_oe(addr_oe), .data_oe(data_oe), .addr_o(addr_o)
);

// File: tb/bus_cycle_ctrl_tb.sv
module bus_cycle_ctrl_tb;
  localparam logic [7:0] VEC = 8'hC7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, req_valid, req_ready, req_fetch, req_intack, done;
  logic [1:0] req_kind;
  logic [19:0] req_addr, addr_o;
  logic [7:0] req_wdata, rdata, data_o, data_i;
  logic wait_n, busreq_n, busack_n, halt_req, halt_n, m1_en, halt_dly_en;
  logic pin_sel, alt_b_i, addr_oe, data_oe, rd_n, wr_n, mreq_n, iorq_n, m1_n;
  logic ctrl_oe, pin_a_o, pin_a_oe, pin_b_o, pin_b_oe;

  bus_cycle_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_fetch(req_fetch), .req_intack(req_intack),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .wait_n(wait_n), .busreq_n(busreq_n), .busack_n(busack_n),
    .halt_req(halt_req), .halt_n(halt_n), .m1_en(m1_en),
    .halt_dly_en(halt_dly_en), .pin_sel(pin_sel), .alt_b_i(alt_b_i),
    .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o), .data_oe(data_oe),
    .data_i(data_i), .rd_n(rd_n), .wr_n(wr_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .m1_n(m1_n), .ctrl_oe(ctrl_oe), .pin_a_o(pin_a_o),
    .pin_a_oe(pin_a_oe), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe)
  );

  function automatic logic [7:0] mem_f(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  assign data_i = (!m1_n && !iorq_n) ? VEC : mem_f(addr_o);

  typedef struct {
    bit is_io; bit is_wr; bit intack; bit exp_m1; bit sel;
    logic [19:0] addr; logic [7:0] data; int len;
  } item_t;

  item_t sbq[$];
  int checks = 0, errors = 0, cur_wait = 0;
  int act_cnt = 0, rd_cnt, wr_cnt, m1_cnt, pa_cnt, pb_cnt, doe_cnt, last_len;
  logic [19:0] addr_seen;
  logic [7:0]  wdata_seen;
  bit io_seen;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: drives wait_n from the cycle position and scores completed cycles
  always @(negedge clk) begin
    if (rst) begin
      wait_n = 1'b1;
      act_cnt = 0;
    end else begin
      if (!mreq_n || !iorq_n) begin
        act_cnt++;
        if (act_cnt == 1) begin
          addr_seen = addr_o; io_seen = !iorq_n;
          rd_cnt = 0; wr_cnt = 0; m1_cnt = 0; pa_cnt = 0; pb_cnt = 0; doe_cnt = 0;
        end
        if (!rd_n) rd_cnt++;
        if (!wr_n) begin wr_cnt++; wdata_seen = data_o; end
        if (data_oe) doe_cnt++;
        if (!m1_n) m1_cnt++;
        if (pin_a_oe && !pin_a_o) pa_cnt++;
        if (pin_b_oe && !pin_b_o) pb_cnt++;
        wait_n = (act_cnt >= 2 && (act_cnt - 2) < cur_wait) ? 1'b0 : 1'b1;
      end else begin
        if (act_cnt > 0) last_len = act_cnt;
        act_cnt = 0;
        wait_n = 1'b1;
      end
      if (done) begin
        if (sbq.size() == 0) chk("R2", "unexpected done", 1, 0);
        else begin
          item_t it;
          it = sbq.pop_front();
          chk("R2/R3", "cycle length", last_len, it.len);
          chk("R5", "address", addr_seen, it.addr);
          chk("R5", "io strobe used", io_seen, it.is_io);
          chk("R2", "rd_n low clocks", rd_cnt, (!it.is_wr && !it.intack) ? it.len : 0);
          chk("R2", "wr_n low clocks", wr_cnt, it.is_wr ? it.len - 1 : 0);
          chk("R4", "data_oe clocks", doe_cnt, it.is_wr ? it.len : 0);
          chk("R6/R7", "m1_n low clocks", m1_cnt, it.exp_m1 ? it.len : 0);
          if (it.is_wr) chk("R4", "write data", wdata_seen, it.data);
          else          chk("R4/R7", "read data", rdata, it.data);
          if (!it.sel) begin
            chk("R8", "pin_a low clocks", pa_cnt, (!it.is_io && !it.is_wr) ? it.len : 0);
            chk("R8", "pin_b low clocks", pb_cnt, (!it.is_io && it.is_wr) ? it.len - 1 : 0);
          end else begin
            chk("R9", "pin_a low clocks", pa_cnt, !it.is_io ? it.len : 0);
            chk("R9", "pin_b low clocks", pb_cnt, 0);
          end
          chk("R10", "busack_n during cycle end", busack_n, 1);
        end
      end
    end
  end

  task automatic run_cyc(input logic [1:0] kind, input bit fetch, input bit intack,
                         input logic [19:0] a, input logic [7:0] wd,
                         input int nw, input bit sel, input bit m1e);
    item_t it;
    it.is_io = kind[1]; it.is_wr = kind[0]; it.intack = intack; it.sel = sel;
    it.addr = kind[1] ? {4'h0, a[15:0]} : a;
    it.len = 3 + nw;
    it.exp_m1 = intack || (fetch && m1e);
    it.data = kind[0] ? wd : (intack ? VEC : mem_f(it.addr));
    @(negedge clk);
    cur_wait = nw; m1_en = m1e; req_kind = kind; req_fetch = fetch;
    req_intack = intack; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    sbq.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_kind = 0; req_fetch = 0; req_intack = 0;
    req_addr = 0; req_wdata = 0; busreq_n = 1; halt_req = 0; m1_en = 1;
    halt_dly_en = 0; pin_sel = 0; alt_b_i = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mreq_n", mreq_n, 1); chk("R1", "iorq_n", iorq_n, 1);
    chk("R1", "rd_n/wr_n/m1_n", {rd_n, wr_n, m1_n}, 3'b111);
    chk("R1", "addr_oe/data_oe", {addr_oe, data_oe}, 2'b00);
    chk("R1", "busack_n/halt_n", {busack_n, halt_n}, 2'b11);
    chk("R1", "pins", {pin_a_o, pin_b_o}, 2'b11);
    chk("R1", "done", done, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "addr_oe idle", addr_oe, 1);

    // R2 R4 R8 memory read/write, R3 waits
    run_cyc(2'b00, 0, 0, 20'h12345, 8'h00, 0, 0, 1);
    run_cyc(2'b01, 0, 0, 20'hABCDE, 8'h3C, 2, 0, 1);
    run_cyc(2'b00, 0, 0, 20'hF0F0F, 8'h00, 5, 0, 1);
    // R5 I/O cycles
    run_cyc(2'b10, 0, 0, 20'hF1234, 8'h00, 0, 0, 1);
    run_cyc(2'b11, 0, 0, 20'h9BEEF, 8'hA5, 1, 0, 1);
    // R6 fetch with and without m1
    run_cyc(2'b00, 1, 0, 20'h00100, 8'h00, 0, 0, 1);
    run_cyc(2'b00, 1, 0, 20'h00101, 8'h00, 1, 0, 0);
    // R7 interrupt acknowledge
    run_cyc(2'b10, 0, 1, 20'h00038, 8'h00, 2, 0, 1);

    // R9 alternate pin functions
    @(negedge clk); pin_sel = 1; alt_b_i = 0;
    @(negedge clk); @(negedge clk);
    chk("R9", "pin_b follows alt", pin_b_o, 0);
    alt_b_i = 1;
    @(negedge clk);
    chk("R9", "pin_b follows alt high", pin_b_o, 1);
    run_cyc(2'b01, 0, 0, 20'h22222, 8'h11, 0, 1, 1);
    run_cyc(2'b00, 0, 0, 20'h33333, 8'h00, 1, 1, 1);
    // R9 mid-cycle select change has no effect on that cycle
    fork
      run_cyc(2'b00, 0, 0, 20'h44444, 8'h00, 3, 1, 1);
      begin repeat (3) @(negedge clk); pin_sel = 0; end
    join
    run_cyc(2'b00, 0, 0, 20'h55555, 8'h00, 0, 0, 1);

    // R10 R11 grant while idle, select 0
    @(negedge clk); busreq_n = 0;
    @(negedge clk);
    chk("R10", "float before ack", {addr_oe, data_oe, ctrl_oe, busack_n}, 4'b0001);
    @(negedge clk);
    chk("R10", "busack_n low", busack_n, 0);
    chk("R10", "pin_a driven high sel0", {pin_a_oe, pin_a_o}, 2'b11);
    busreq_n = 1;
    @(negedge clk);
    chk("R11", "busack_n released", busack_n, 1);
    chk("R11", "addr_oe restored", addr_oe, 1);

    // R10 grant with select 1 floats pin_a
    pin_sel = 1;
    @(negedge clk); busreq_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R10", "pin_a floated sel1", pin_a_oe, 0);
    busreq_n = 1;
    @(negedge clk);
    chk("R11", "busack_n released sel1", busack_n, 1);
    pin_sel = 0;
    @(negedge clk);

    // R10 grant waits for cycle in progress
    fork
      run_cyc(2'b00, 0, 0, 20'h66666, 8'h00, 4, 0, 1);
      begin
        repeat (3) @(negedge clk);
        busreq_n = 0;
        while (busack_n) @(negedge clk);
        chk("R10", "cycle finished before ack", sbq.size(), 0);
        busreq_n = 1;
      end
    join
    @(negedge clk);

    // R12 halt
    halt_req = 1;
    @(negedge clk);
    chk("R12", "halt_n low", halt_n, 0);
    chk("R12", "buses floated", {addr_oe, data_oe}, 2'b00);
    req_valid = 1; req_kind = 2'b00; req_addr = 20'h77777;
    repeat (4) @(negedge clk);
    chk("R12", "no request accepted", {req_ready, mreq_n}, 2'b01);
    req_valid = 0;

    // R13 restart gap without delay
    halt_dly_en = 0;
    halt_req = 0;
    fork
      run_cyc(2'b00, 1, 0, 20'h00200, 8'h00, 0, 0, 1);
      begin
        int n = 0;
        do begin @(negedge clk); n++; end while (mreq_n);
        chk("R13", "restart gap no delay", n, 2);
      end
    join
    @(negedge clk);
    halt_dly_en = 1; halt_req = 1;
    repeat (2) @(negedge clk);
    halt_req = 0;
    fork
      run_cyc(2'b00, 1, 0, 20'h00300, 8'h00, 0, 0, 1);
      begin
        int n = 0;
        do begin @(negedge clk); n++; end while (mreq_n);
        chk("R13", "restart gap with delay", n, 18);
      end
    join
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule